// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block decides, every clock cycle, which instruction address a small controller fetches next. It decodes the 18-bit instruction word presented at the current program counter. Ordinary instructions step the counter by one. Branch words can jump, call a subroutine, return, return from an interrupt handler, or change the interrupt-enable state. Each branch word is taken only when its condition field holds against the zero and carry flags supplied by the arithmetic unit.

Calls and interrupt entries store their return addresses in a small circular stack, and returns take them back out. An interrupt request is honoured only while interrupts are enabled. When it is honoured, the instruction in that cycle is dropped, its address is saved and execution moves to a fixed vector. The flags present at entry are also saved. A return from interrupt gives them back to the arithmetic unit through a one-cycle restore strobe.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is held, the program counter is 0, interrupts are disabled and the restore strobe is low. Reset also empties the return stack, so that every slot holds 0 and the pointer stands at slot 0.
- R2: A branch word holds the branch code in bits 17:13, the condition in bits 12:10 and the target in bits 9:0. The codes are: return 10101, call 11000, jump 11010, return-from-interrupt 11100, interrupt-enable 11110. Any other value in bits 17:13, including near misses such as 10100 or 11011, is an ordinary instruction.
- R3: Condition 100 holds when zero is set and 101 when zero is clear. Condition 110 holds when carry is set and 111 when carry is clear. Any condition with bit 12 clear (000 included) always holds. A branch whose condition fails behaves as an ordinary instruction.
- R4: An ordinary instruction or an untaken branch sets the next PC to PC+1, modulo 1024, so 0x3FF wraps to 0x000.
- R5: A taken jump loads the target into the PC.
- R6: A taken call stores PC+1 on the return stack and loads the target into the PC.
- R7: A taken return loads the PC from the most recently stored stack entry and removes that entry. Its target bits have no effect.
- R8: The stack has 16 slots. Its pointer wraps in both directions: a 17th store overwrites the oldest slot, and a removal from an empty stack reads slot 15.
- R9: A taken interrupt-enable word sets the enable state to bit 0 of the word (1 enables, 0 disables).
- R10: An interrupt request while interrupts are enabled takes priority over the current instruction, which is then not executed. The block stores the current PC (not PC+1) on the stack, moves the PC to 0x3FF, disables interrupts and saves the zero and carry inputs. A request while interrupts are disabled has no effect.
- R11: A taken return-from-interrupt loads the PC from the stack and sets interrupt enable to 1. In that same cycle it raises the restore strobe, with the saved zero and carry on the restore outputs. In every other cycle the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 18 | Instruction word at the current PC |
| flag_zero | input | 1 | Zero flag from the arithmetic unit |
| flag_carry | input | 1 | Carry flag from the arithmetic unit |
| irq_req | input | 1 | Interrupt request |
| pc | output | 10 | Program counter |
| int_enable | output | 1 | Interrupt enable state |
| flag_restore | output | 1 | Strobe: arithmetic unit reloads its flags from the restore outputs |
| restore_zero | output | 1 | Zero flag saved at interrupt entry |
| restore_carry | output | 1 | Carry flag saved at interrupt entry |

## Verification
Interrupt entry and branch execution can fall in the same cycle. The bench provokes this by raising the request while a taken call sits on the instruction input, and again while a return-from-interrupt does. The expected result is that the interrupt wins. The saved address must be the call's own address, the stack must gain exactly one entry, and the restore strobe must stay low. A later return-from-interrupt must then come back to the dropped call, which runs normally. A random phase mixes requests with every branch kind, and a behavioural model judges each cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int CODE_W = 5;
  localparam int COND_W = 3;

  localparam logic [CODE_W-1:0] CODE_RET  = 5'b10101;
  localparam logic [CODE_W-1:0] CODE_CALL = 5'b11000;
  localparam logic [CODE_W-1:0] CODE_JUMP = 5'b11010;
  localparam logic [CODE_W-1:0] CODE_RETI = 5'b11100;
  localparam logic [CODE_W-1:0] CODE_IEN  = 5'b11110;

  typedef enum logic [2:0] {
    OP_SEQ,
    OP_JUMP,
    OP_CALL,
    OP_RET,
    OP_RETI,
    OP_IEN
  } br_op_e;

  // Bit 2 clear: unconditional. Otherwise bit 1 picks carry over zero,
  // bit 0 inverts the sense.
  function automatic logic cond_holds(input logic [COND_W-1:0] cnd,
                                      input logic z, input logic c);
    logic sel;
    if (!cnd[2]) return 1'b1;
    sel = cnd[1] ? c : z;
    return sel ^ cnd[0];
  endfunction

  function automatic br_op_e classify(input logic [CODE_W-1:0] code);
    case (code)
      CODE_JUMP: return OP_JUMP;
      CODE_CALL: return OP_CALL;
      CODE_RET:  return OP_RET;
      CODE_RETI: return OP_RETI;
      CODE_IEN:  return OP_IEN;
      default:   return OP_SEQ;
    endcase
  endfunction

endpackage

// File: rtl/br_decode.sv
module br_decode
  import seq_pkg::*;
#(
  parameter int INSTR_W = 18,
  parameter int ADDR_W  = 10
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic               flag_zero,
  input  logic               flag_carry,
  output br_op_e             op,
  output logic               cond_ok,
  output logic [ADDR_W-1:0]  target
);

  localparam int CODE_LSB = INSTR_W - CODE_W;
  localparam int COND_LSB = CODE_LSB - COND_W;

  logic [CODE_W-1:0] code_f;
  logic [COND_W-1:0] cond_f;

  assign code_f  = instr[CODE_LSB +: CODE_W];
  assign cond_f  = instr[COND_LSB +: COND_W];
  assign target  = instr[ADDR_W-1:0];
  assign op      = classify(code_f);
  assign cond_ok = cond_holds(cond_f, flag_zero, flag_carry);

endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] push_data,
  output logic [DATA_W-1:0] top_data
);

  localparam int SPW = $clog2(DEPTH);

  logic [SPW-1:0]    sp_q;
  logic [SPW-1:0]    top_idx;
  logic [DATA_W-1:0] slots [DEPTH];

  assign top_idx = sp_q - SPW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)    sp_q <= '0;
    else if (push) sp_q <= sp_q + SPW'(1);
    else if (pop)  sp_q <= top_idx;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                             slot_q <= '0;
      else if (push && sp_q == SPW'(g))       slot_q <= push_data;
    end
    assign slots[g] = slot_q;
  end

  assign top_data = slots[top_idx];

  assert_no_push_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

  assert_push_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> top_data == $past(push_data));

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import seq_pkg::*;
#(
  parameter int              ADDR_W      = 10,
  parameter int              INSTR_W     = 18,
  parameter int              STACK_DEPTH = 16,
  parameter logic [ADDR_W-1:0] IRQ_VEC   = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr,
  input  logic               flag_zero,
  input  logic               flag_carry,
  input  logic               irq_req,
  output logic [ADDR_W-1:0]  pc,
  output logic               int_enable,
  output logic               flag_restore,
  output logic               restore_zero,
  output logic               restore_carry
);

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  logic [ADDR_W-1:0] pc_q, pc_d, pc_plus1, target, stack_top, push_data;
  logic              ie_q, ie_d, sav_z_q, sav_c_q;
  br_op_e            op;
  logic              cond_ok;

  // Named internal events
  logic irq_take, taken, jump_go, call_go, ret_go, reti_go, ien_go;
  logic push, pop;

  br_decode #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W)) u_dec (
    .instr(instr), .flag_zero(flag_zero), .flag_carry(flag_carry),
    .op(op), .cond_ok(cond_ok), .target(target)
  );

  assign pc_plus1 = step_addr(pc_q);
  assign irq_take = irq_req & ie_q;
  assign taken    = !irq_take && cond_ok && (op != OP_SEQ);
  assign jump_go  = taken && (op == OP_JUMP);
  assign call_go  = taken && (op == OP_CALL);
  assign ret_go   = taken && (op == OP_RET);
  assign reti_go  = taken && (op == OP_RETI);
  assign ien_go   = taken && (op == OP_IEN);

  assign push      = irq_take | call_go;
  assign pop       = ret_go | reti_go;
  assign push_data = irq_take ? pc_q : pc_plus1;

  ret_stack #(.DEPTH(STACK_DEPTH), .DATA_W(ADDR_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .push_data(push_data), .top_data(stack_top)
  );

  always_comb begin
    if (irq_take)                pc_d = IRQ_VEC;
    else if (jump_go || call_go) pc_d = target;
    else if (pop)                pc_d = stack_top;
    else                         pc_d = pc_plus1;
  end

  always_comb begin
    if (irq_take)     ie_d = 1'b0;
    else if (reti_go) ie_d = 1'b1;
    else if (ien_go)  ie_d = instr[0];
    else              ie_d = ie_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '0;
      ie_q    <= 1'b0;
      sav_z_q <= 1'b0;
      sav_c_q <= 1'b0;
    end else begin
      pc_q <= pc_d;
      ie_q <= ie_d;
      if (irq_take) begin
        sav_z_q <= flag_zero;
        sav_c_q <= flag_carry;
      end
    end
  end

  assign pc            = pc_q;
  assign int_enable    = ie_q;
  assign flag_restore  = reti_go;
  assign restore_zero  = sav_z_q;
  assign restore_carry = sav_c_q;

  assert_irq_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (pc == IRQ_VEC) && !int_enable);

  assert_jump_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    jump_go |=> pc == $past(target));

  assert_call_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    call_go |=> pc == $past(target));

  assert_ret_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_go |=> pc == $past(stack_top));

  assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_take && op == OP_SEQ) |=> pc == ADDR_W'($past(pc) + 1'b1));

  assert_ien_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ien_go |=> int_enable == $past(instr[0]));

  assert_reti_ie_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_restore |=> int_enable);

endmodule

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;

  localparam logic [4:0] C_RET  = 5'b10101;
  localparam logic [4:0] C_CALL = 5'b11000;
  localparam logic [4:0] C_JUMP = 5'b11010;
  localparam logic [4:0] C_RETI = 5'b11100;
  localparam logic [4:0] C_IEN  = 5'b11110;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] instr = '0;
  logic        flag_zero = 1'b0, flag_carry = 1'b0, irq_req = 1'b0;
  logic [9:0]  pc;
  logic        int_enable, flag_restore, restore_zero, restore_carry;

  int errors = 0;
  int checks = 0;

  // Reference model state
  int m_pc = 0, m_ie = 0, m_sp = 0, m_sz = 0, m_sc = 0;
  int m_stk [16];

  always #2 clk = ~clk;

  pc_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .flag_zero(flag_zero),
    .flag_carry(flag_carry), .irq_req(irq_req), .pc(pc),
    .int_enable(int_enable), .flag_restore(flag_restore),
    .restore_zero(restore_zero), .restore_carry(restore_carry)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] mk(input logic [4:0] code,
                                     input logic [2:0] cnd,
                                     input logic [9:0] addr);
    return {code, cnd, addr};
  endfunction

  // One cycle: drive, check the strobe, advance the model, check registers.
  task automatic step(input logic [17:0] ins, input bit z, input bit c,
                      input bit irq, input string force_tag);
    logic [4:0] code;
    logic [2:0] cnd;
    int tgt;
    bit ok, irqt, br, exp_rs;
    string tag;
    @(negedge clk);
    instr = ins; flag_zero = z; flag_carry = c; irq_req = irq;
    #1;
    code = ins[17:13]; cnd = ins[12:10]; tgt = int'(ins[9:0]);
    case (cnd)
      3'b100: ok = z;
      3'b101: ok = !z;
      3'b110: ok = c;
      3'b111: ok = !c;
      default: ok = 1'b1;
    endcase
    br = (code == C_RET) || (code == C_CALL) || (code == C_JUMP) ||
         (code == C_RETI) || (code == C_IEN);
    irqt = irq && (m_ie != 0);
    exp_rs = !irqt && br && ok && (code == C_RETI);
    chk("R11 strobe", int'(flag_restore), int'(exp_rs));
    if (exp_rs) begin
      chk("R11 zero", int'(restore_zero), m_sz);
      chk("R11 carry", int'(restore_carry), m_sc);
    end
    if (irqt) begin
      tag = "R10";
      m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 16;
      m_pc = 1023; m_ie = 0; m_sz = int'(z); m_sc = int'(c);
    end else if (!br) begin
      tag = "R4";
      m_pc = (m_pc + 1) % 1024;
    end else if (!ok) begin
      tag = "R3";
      m_pc = (m_pc + 1) % 1024;
    end else begin
      case (code)
        C_JUMP: begin tag = "R5"; m_pc = tgt; end
        C_CALL: begin
          tag = "R6";
          m_stk[m_sp] = (m_pc + 1) % 1024; m_sp = (m_sp + 1) % 16; m_pc = tgt;
        end
        C_RET: begin
          tag = "R7";
          m_sp = (m_sp + 15) % 16; m_pc = m_stk[m_sp];
        end
        C_RETI: begin
          tag = "R11";
          m_sp = (m_sp + 15) % 16; m_pc = m_stk[m_sp]; m_ie = 1;
        end
        default: begin
          tag = "R9";
          m_ie = int'(ins[0]); m_pc = (m_pc + 1) % 1024;
        end
      endcase
    end
    if (force_tag != "") tag = force_tag;
    @(posedge clk); #1;
    chk({tag, " pc"}, int'(pc), m_pc);
    chk({tag, " ie"}, int'(int_enable), m_ie);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_stk[i] = 0;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pc", int'(pc), 0);
    chk("R1 ie", int'(int_enable), 0);
    chk("R1 strobe", int'(flag_restore), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1: empty stack reads slot 15 holding 0 after reset
    step(mk(C_RET, 3'b000, 10'h155), 0, 0, 0, "R1");
    // R4: sequential steps
    step(18'h00000, 0, 0, 0, "");
    step(18'h0ABCD, 1, 1, 0, "");
    // R2: near-miss codes are ordinary
    step(mk(5'b10100, 3'b000, 10'h222), 0, 0, 0, "R2");
    step(mk(5'b11011, 3'b000, 10'h222), 0, 0, 0, "R2");
    step(mk(5'b11111, 3'b000, 10'h222), 0, 0, 0, "R2");
    step(mk(C_JUMP, 3'b000, 10'h123), 0, 0, 0, "R2");
    // R4: wrap 0x3FF -> 0
    step(mk(C_JUMP, 3'b000, 10'h3FF), 0, 0, 0, "R5");
    step(18'h00000, 0, 0, 0, "R4");
    // R3: each condition taken and not taken
    for (int k = 0; k < 8; k++) begin
      step(mk(C_JUMP, 3'b100, 10'h040 + 10'(k)), k[0], k[1], 0, "R3");
      step(mk(C_JUMP, 3'b101, 10'h080 + 10'(k)), k[0], k[1], 0, "R3");
      step(mk(C_JUMP, 3'b110, 10'h0C0 + 10'(k)), k[0], k[1], 0, "R3");
      step(mk(C_JUMP, 3'b111, 10'h100 + 10'(k)), k[0], k[1], 0, "R3");
      step(mk(C_JUMP, 3'(k & 3), 10'h140 + 10'(k)), k[0], k[1], 0, "R3");
    end
    // R6/R7: call then return whose target bits are all ones
    step(mk(C_CALL, 3'b000, 10'h200), 0, 0, 0, "R6");
    step(18'h00000, 0, 0, 0, "");
    step(mk(C_RET, 3'b000, 10'h3FF), 0, 0, 0, "R7");
    step(mk(C_RET, 3'b101, 10'h000), 1, 0, 0, "R3");
    // R10: request ignored while disabled
    step(18'h00000, 1, 1, 1, "R10");
    // R9: enable, disable, enable
    step(mk(C_IEN, 3'b000, 10'h001), 0, 0, 0, "R9");
    step(mk(C_IEN, 3'b000, 10'h000), 0, 0, 0, "R9");
    step(mk(C_IEN, 3'b110, 10'h001), 0, 0, 0, "R9");
    step(mk(C_IEN, 3'b000, 10'h001), 0, 0, 0, "R9");
    // R10: request collides with a taken call; interrupt wins
    step(mk(C_JUMP, 3'b000, 10'h050), 0, 0, 0, "");
    step(mk(C_CALL, 3'b000, 10'h300), 1, 0, 1, "R10");
    step(18'h00000, 0, 1, 0, "");
    // R11: return-from-interrupt restores flags, resumes at the call
    step(mk(C_RETI, 3'b000, 10'h3FF), 0, 1, 0, "R11");
    step(mk(C_CALL, 3'b000, 10'h300), 0, 0, 0, "R6");
    step(mk(C_RET, 3'b000, 10'h000), 0, 0, 0, "R7");
    // R10: request collides with a return-from-interrupt
    step(mk(C_RETI, 3'b000, 10'h000), 1, 1, 1, "R10");
    step(mk(C_RETI, 3'b000, 10'h000), 0, 0, 0, "R11");
    // R8: 17 calls overflow, 18 returns underflow
    step(mk(C_IEN, 3'b000, 10'h000), 0, 0, 0, "R9");
    for (int k = 0; k < 17; k++)
      step(mk(C_CALL, 3'b000, 10'(16 * k + 3)), 0, 0, 0, "R8");
    for (int k = 0; k < 18; k++)
      step(mk(C_RET, 3'b000, 10'h000), 0, 0, 0, "R8");
    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] code;
      int sel = int'($urandom_range(0, 7));
      case (sel)
        0: code = C_RET;
        1: code = C_CALL;
        2: code = C_JUMP;
        3: code = C_RETI;
        4: code = C_IEN;
        default: code = {1'b0, 4'($urandom)};
      endcase
      step(mk(code, 3'($urandom), 10'($urandom)), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 5) == 0), "");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule